// File: doc/BRIEF.md
# Nibble Stream Cadence Re-timer

This block takes a receive nibble stream (4-bit data, a data-valid level and an error flag) whose transfers are qualified by a one-cycle enable strobe. The strobe comes from a receive PCS and its spacing wanders around one-in-five cycles, because the far-end transmit clock and the local 125 MHz clock differ slightly. The block re-times that stream onto a strictly periodic enable strobe that it generates itself. All of this happens inside one fast clock, so there is no clock-domain crossing. The output feeds a MAC that expects perfectly even enable spacing.

A small FIFO absorbs the drift over the length of one frame. When a frame starts, the output is held back until the FIFO holds a set number of nibbles. The buffer then releases one entry per output strobe. When the incoming frame ends, the remaining entries drain and the block goes back to idle with empty pointers. There are two fault cases. If the FIFO is full when a nibble arrives, that nibble is dropped. If the FIFO runs dry while the frame is still in progress, a filler nibble is sent. In both cases the output error flag is raised for the rest of the frame.

Top module: `mii_cadence_buffer`

## Requirements
- R1: `out_ce` is high for exactly one cycle in every PERIOD cycles. The spacing never varies, whatever the input does.
- R2: While `rst` is high, and in the first cycle after it is released, `out_ce`, `out_dv`, `out_err` and `out_data` are all 0.
- R3: `out_data`, `out_dv` and `out_err` change only in a cycle where `out_ce` is 1. In every other cycle they hold their previous values.
- R4: With no fault, every nibble accepted in a frame appears exactly once, in arrival order and with unchanged data, as one contiguous run of `out_dv`=1 strobes.
- R5: `out_dv` does not rise for a frame until at least min(FILL_LVL, frame length) of that frame's nibbles have been accepted.
- R6: After the input frame ends (an `in_ce` strobe with `in_dv`=0), the entries still buffered are delivered. `out_dv` then falls to 0, and the next frame is handled like the first one after reset.
- R7: An input nibble that carries `in_err`=1 is delivered with `out_err`=1 on that same output nibble. Neighbouring nibbles are not marked.
- R8: A nibble that arrives while DEPTH entries are buffered is discarded. The surviving nibbles keep their order. Every nibble output after the discard carries `out_err`=1 until the frame ends, and the next frame starts clean.
- R9: If an output strobe finds the FIFO empty while the input frame is still open, the block outputs `out_dv`=1, `out_err`=1 and `out_data`=0. Every later nibble of that frame carries `out_err`=1.
- R10: Input strobes with `in_dv`=0 outside a frame have no effect: `out_dv` stays 0 whatever `in_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single fast clock |
| rst | input | 1 | Synchronous active-high reset |
| in_ce | input | 1 | Irregular input transfer strobe |
| in_data | input | 4 | Input nibble |
| in_dv | input | 1 | Input data-valid level, sampled on `in_ce` |
| in_err | input | 1 | Input error flag, sampled on `in_ce` |
| out_ce | output | 1 | Regular output strobe, one cycle in PERIOD |
| out_data | output | 4 | Output nibble, valid with `out_ce` |
| out_dv | output | 1 | Output data-valid |
| out_err | output | 1 | Output error flag |

## Verification
The bench builds the block with DEPTH=4, PERIOD=5 and FILL_LVL=2. At this depth, a burst of back-to-back input strobes fills the FIFO within a few cycles, and a short stall in mid-frame empties it, so both fault paths are easy to reach. The bench sweeps every frame length from 1 to 12, every input phase against the output strobe, and three input cadences: exact, slightly fast and slightly slow. This covers frames shorter than the fill level, frames that end during pre-fill, and drift on either side of nominal.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

  localparam int NIB_W = 4;

  typedef struct packed {
    logic             dv;
    logic             err;
    logic [NIB_W-1:0] nib;
  } mii_word_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_RUN  = 2'd2
  } buf_state_t;

  localparam mii_word_t WORD_IDLE = '{dv: 1'b0, err: 1'b0, nib: '0};

endpackage

// File: rtl/mcb_strobe.sv
module mcb_strobe #(
  parameter int PERIOD = 5
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  // free-running modulo-PERIOD phase counter
  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) < PERIOD) else $error("phase counter out of range"); // R1

  generate
    if (PERIOD > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick) else $error("back-to-back strobe"); // R1
    end
  endgenerate

endmodule

// File: rtl/mcb_fifo.sv
module mcb_fifo
  import mcb_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            push,
  input  mii_word_t       din,
  input  logic            pop,
  output mii_word_t       head,
  output logic [CNTW-1:0] count,
  output logic            ovf
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);

  mii_word_t       mem [DEPTH];
  logic [PW-1:0]   wr_ptr_q, rd_ptr_q;
  logic [CNTW-1:0] count_q;
  logic            full, empty, wr_go, rd_go;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count_q == CNT_FULL);
  assign empty = (count_q == '0);
  assign wr_go = push && !full;
  assign rd_go = pop && !empty;
  assign ovf   = push && full;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_go) mem[wr_ptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_go) wr_ptr_q <= step(wr_ptr_q);
      if (rd_go) rd_ptr_q <= step(rd_ptr_q);
      case ({wr_go, rd_go})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head  = mem[rd_ptr_q];
  assign count = count_q;

  AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty) else $error("read request on empty buffer"); // R9

  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_FULL) else $error("occupancy beyond depth"); // R8

endmodule

// File: rtl/mcb_ctrl.sv
module mcb_ctrl
  import mcb_pkg::*;
#(
  parameter int FILL_LVL = 4,
  parameter int CNTW     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_ce,
  input  logic            in_dv,
  input  logic            push,
  input  logic            tick,
  input  logic [CNTW-1:0] count,
  input  logic            ovf,
  input  mii_word_t       head,
  output logic            pop,
  output logic            clr,
  output logic            out_ce,
  output mii_word_t       out_word
);

  localparam logic [CNTW-1:0] FILL_CNT = CNTW'(FILL_LVL);

  buf_state_t state_q, state_d;
  logic       in_frame_q, sticky_q;
  logic       under, finish;
  logic       out_ce_q;
  mii_word_t  out_word_q;

  // tracks whether the incoming frame is still open
  always_ff @(posedge clk) begin
    if (rst)        in_frame_q <= 1'b0;
    else if (in_ce) in_frame_q <= in_dv;
  end

  always_comb begin
    pop    = 1'b0;
    under  = 1'b0;
    finish = 1'b0;
    if (state_q == ST_RUN && tick) begin
      if (count != '0)     pop    = 1'b1;
      else if (in_frame_q) under  = 1'b1;
      else                 finish = 1'b1;
    end
    clr = (state_q == ST_IDLE) && (count == '0) && !push;

    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (count != '0) state_d = ST_FILL;
      ST_FILL: if (count >= FILL_CNT || !in_frame_q) state_d = ST_RUN;
      ST_RUN:  if (finish) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // frame-long error marking after a drop or a starved strobe
  always_ff @(posedge clk) begin
    if (rst)                sticky_q <= 1'b0;
    else if (finish)        sticky_q <= 1'b0;
    else if (ovf || under)  sticky_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_ce_q   <= 1'b0;
      out_word_q <= WORD_IDLE;
    end else begin
      out_ce_q <= tick;
      if (tick) begin
        if (pop)
          out_word_q <= '{dv: head.dv, err: head.err | sticky_q, nib: head.nib};
        else if (under)
          out_word_q <= '{dv: 1'b1, err: 1'b1, nib: '0};
        else
          out_word_q <= WORD_IDLE;
      end
    end
  end

  assign out_ce   = out_ce_q;
  assign out_word = out_word_q;

  AST_ERR_STICKS: assert property (@(posedge clk) disable iff (rst)
    sticky_q && pop |=> out_word_q.err) else $error("error mark lost"); // R8

  AST_FILL_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FILL) && tick |=> !out_word_q.dv) else $error("output during pre-fill"); // R5

endmodule

// File: rtl/mii_cadence_buffer.sv
module mii_cadence_buffer
  import mcb_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int PERIOD   = 5,
  parameter int FILL_LVL = DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_ce,
  input  logic [NIB_W-1:0] in_data,
  input  logic             in_dv,
  input  logic             in_err,
  output logic             out_ce,
  output logic [NIB_W-1:0] out_data,
  output logic             out_dv,
  output logic             out_err
);

  localparam int CNTW = $clog2(DEPTH + 1);

  logic            tick, push, pop, clr, ovf;
  logic [CNTW-1:0] count;
  mii_word_t       din, head, out_word;

  assign push = in_ce && in_dv;
  assign din  = '{dv: in_dv, err: in_err, nib: in_data};

  mcb_strobe #(.PERIOD(PERIOD)) u_strobe (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  mcb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .push  (push),
    .din   (din),
    .pop   (pop),
    .head  (head),
    .count (count),
    .ovf   (ovf)
  );

  mcb_ctrl #(.FILL_LVL(FILL_LVL), .CNTW(CNTW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_ce    (in_ce),
    .in_dv    (in_dv),
    .push     (push),
    .tick     (tick),
    .count    (count),
    .ovf      (ovf),
    .head     (head),
    .pop      (pop),
    .clr      (clr),
    .out_ce   (out_ce),
    .out_word (out_word)
  );

  assign out_data = out_word.nib;
  assign out_dv   = out_word.dv;
  assign out_err  = out_word.err;

  AST_HOLD_OFF_STROBE: assert property (@(posedge clk) disable iff (rst)
    !out_ce |-> ($stable(out_data) && $stable(out_dv) && $stable(out_err)))
    else $error("output moved without strobe"); // R3

endmodule

// File: tb/tb_mii_cadence_buffer.sv
module tb_mii_cadence_buffer;

  localparam int DEPTH  = 4;
  localparam int PERIOD = 5;
  localparam int FILL   = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_ce = 1'b0, in_dv = 1'b0, in_err = 1'b0;
  logic [3:0] in_data = 4'h0;
  logic       out_ce, out_dv, out_err;
  logic [3:0] out_data;

  mii_cadence_buffer #(.DEPTH(DEPTH), .PERIOD(PERIOD), .FILL_LVL(FILL)) dut (
    .clk(clk), .rst(rst), .in_ce(in_ce), .in_data(in_data), .in_dv(in_dv),
    .in_err(in_err), .out_ce(out_ce), .out_data(out_data), .out_dv(out_dv),
    .out_err(out_err)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // monitor state
  logic [4:0] cap [64];
  int ncap = 0, rises = 0, nwr = 0, wr_at_rise = -1;
  logic prev_dv = 1'b0;
  int since_ce = 0, ce_bad = 0, ce_count = 0;
  bit ce_seen = 0;
  int hold_bad = 0;
  logic [3:0] pd = 4'h0;
  logic pdv = 1'b0, perr = 1'b0;

  logic [3:0] tx_nib [64];
  logic       tx_err [64];

  always @(negedge clk) begin
    if (!rst) begin
      since_ce++;
      if (!out_ce && (out_data !== pd || out_dv !== pdv || out_err !== perr)) hold_bad++;
      if (out_ce) begin
        if (ce_seen && since_ce != PERIOD) ce_bad++;
        since_ce = 0;
        ce_seen = 1;
        ce_count++;
        if (out_dv && !prev_dv) begin
          rises++;
          if (wr_at_rise < 0) wr_at_rise = nwr;
        end
        if (out_dv && ncap < 64) begin
          cap[ncap] = {out_err, out_data};
          ncap++;
        end
        prev_dv = out_dv;
      end
      if (in_ce && in_dv) nwr++;
    end
    pd = out_data; pdv = out_dv; perr = out_err;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    ncap = 0; rises = 0; nwr = 0; wr_at_rise = -1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1 in_ce = 1'b0;
    end
  endtask

  task automatic pulse(input logic dv, input logic [3:0] d, input logic e);
    @(posedge clk); #1;
    in_ce = 1'b1; in_dv = dv; in_data = d; in_err = e;
  endtask

  task automatic quiet_tail();
    pulse(1'b0, 4'h0, 1'b0);
    for (int k = 0; k < 16; k++) begin
      idle(4);
      pulse(1'b0, 4'hF, 1'b0);
    end
    idle(4);
  endtask

  task automatic run_frame(input int len, input int phase, input int mode, input int errpos);
    int mism, emis, need;
    clear_mon();
    for (int i = 0; i < len; i++) begin
      tx_nib[i] = 4'((i * 7 + len + phase) & 15);
      tx_err[i] = (i == errpos);
    end
    idle(phase);
    for (int i = 0; i < len; i++) begin
      int gap;
      pulse(1'b1, tx_nib[i], tx_err[i]);
      gap = PERIOD;
      if (i % 4 == 3) gap = (mode == 1) ? PERIOD - 1 : (mode == 2) ? PERIOD + 1 : PERIOD;
      idle(gap - 1);
    end
    quiet_tail();
    mism = 0; emis = 0;
    for (int i = 0; i < len && i < ncap; i++) begin
      if (cap[i][3:0] != tx_nib[i]) mism++;
      if (cap[i][4] != tx_err[i]) emis++;
    end
    need = (len < FILL) ? len : FILL;
    check(ncap == len, "R4 nibble count", ncap, len);
    check(mism == 0, "R4 data order", mism, 0);
    check(emis == 0, (errpos >= 0) ? "R7 error pass-through" : "R4 no error", emis, 0);
    check(rises == 1, "R4 contiguous valid", rises, 1);
    check(wr_at_rise >= need, "R5 prefill", wr_at_rise, need);
    check(out_dv == 1'b0, "R6 drained to idle", int'(out_dv), 0);
  endtask

  initial begin
    int first_err, bad_after, inc_bad, nz, nz_bad;
    logic [3:0] last;
    // R2 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_ce == 1'b0 && out_dv == 1'b0 && out_err == 1'b0 && out_data == 4'h0,
          "R2 outputs in reset", int'({out_ce, out_dv, out_err}), 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(out_ce == 1'b0 && out_dv == 1'b0 && out_data == 4'h0,
          "R2 first cycle after reset", int'({out_ce, out_dv}), 0);
    idle(10);

    // R10: strobes without data-valid outside a frame
    clear_mon();
    for (int k = 0; k < 30; k++) begin
      pulse(1'b0, 4'(k), 1'b0);
      idle(2);
    end
    idle(20);
    check(ncap == 0 && rises == 0, "R10 idle strobes ignored", ncap, 0);

    // R4 R5 R6 R7 sweep of length, phase and cadence
    for (int len = 1; len <= 12; len++)
      for (int ph = 0; ph < PERIOD; ph++)
        for (int md = 0; md < 3; md++)
          run_frame(len, ph, md, (md == 0 && ph == 2 && len > 3) ? 2 : -1);

    // R8 overflow: back-to-back input strobes
    clear_mon();
    for (int i = 0; i < 10; i++) pulse(1'b1, 4'(i + 1), 1'b0);
    quiet_tail();
    first_err = -1; bad_after = 0; inc_bad = 0; last = 4'h0;
    for (int i = 0; i < ncap; i++) begin
      if (cap[i][4] && first_err < 0) first_err = i;
      if (first_err >= 0 && !cap[i][4]) bad_after++;
      if (cap[i][3:0] <= last) inc_bad++;
      last = cap[i][3:0];
    end
    check(ncap >= DEPTH && ncap < 10, "R8 nibbles dropped", ncap, DEPTH);
    check(first_err >= 0, "R8 error marked", first_err, 0);
    check(bad_after == 0, "R8 error held to frame end", bad_after, 0);
    check(inc_bad == 0, "R8 survivors in order", inc_bad, 0);
    run_frame(6, 0, 0, -1);  // R8 next frame clean

    // R9 underflow: stall in mid-frame
    clear_mon();
    for (int i = 0; i < 3; i++) begin pulse(1'b1, 4'(i + 1), 1'b0); idle(PERIOD - 1); end
    idle(40);
    for (int i = 3; i < 6; i++) begin pulse(1'b1, 4'(i + 1), 1'b0); idle(PERIOD - 1); end
    quiet_tail();
    check(ncap > 6, "R9 filler nibbles present", ncap, 7);
    check(cap[0] == 5'h01 && cap[1] == 5'h02 && cap[2] == 5'h03,
          "R9 clean before stall", int'(cap[2]), 3);
    check(cap[3] == 5'h10, "R9 starved nibble", int'(cap[3]), 16);
    bad_after = 0; nz = 0; nz_bad = 0;
    for (int i = 3; i < ncap; i++) begin
      if (!cap[i][4]) bad_after++;
      if (cap[i][3:0] != 4'h0) begin
        if (cap[i][3:0] != 4'(nz + 4)) nz_bad++;
        nz++;
      end
    end
    check(bad_after == 0, "R9 error held to frame end", bad_after, 0);
    check(nz == 3 && nz_bad == 0, "R9 late data delivered", nz, 3);
    run_frame(5, 1, 0, -1);  // R6 recovery after fault

    // R1 strobe spacing, R3 hold between strobes
    check(ce_bad == 0 && ce_count > 100, "R1 regular strobe", ce_bad, 0);
    check(hold_bad == 0, "R3 outputs hold off strobe", hold_bad, 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule